// File: doc/BRIEF.md
# Burst-Aware Datapath Power-Down Sequencer

This block decides when the clocks of a transmit signal-processing chain may stop. Three conditions can ask for that: a hardware power-down input, an optional automatic mode that sleeps the chain between transmit bursts, and a full-sleep control bit that also shuts down the analog section. Before the datapath clock enable drops, the sequencer keeps the chain clocked for a fixed number of flush cycles. This clears the chain, so the next burst starts from clean filter state.

When transmit-enable is high and nothing else asks for power-down, a gated or draining datapath is handed back at once. The data output clock enable keeps running in every digital power-down state, so downstream timing stays aligned. On leaving full sleep, the block reports not ready until the PLL lock indicator has been seen high. The chain's clock gating cells, the filters and the analog circuitry sit outside this block.

Top module: `burst_pd_seq`

## Requirements
- R1: After a synchronous active-low reset, state_o is RUN (encoding RUN=0, FLUSH=1, GATED=2, SLEEP=3, WAIT_LOCK=4). dp_clk_en, ready and out_clk_en are 1 and ana_shutdown is 0.
- R2: When pd_pin is high in RUN, the block enters FLUSH at the next edge. dp_clk_en stays 1 for exactly FLUSH_CYCLES cycles in FLUSH, and then the state becomes GATED with dp_clk_en 0.
- R3: When pd_pin is low in GATED and no other power-down cause is present, the block returns to RUN at the next edge. If pd_pin falls in the same cycle that tx_en rises, dp_clk_en is 1 in that cycle and the state is RUN after the edge.
- R4: When auto_pd_en is 1, a low tx_en in RUN causes a flush and then GATED. When auto_pd_en is 0, a low tx_en has no effect and the state stays RUN.
- R5: In GATED with auto mode, while pd_pin and sleep_req are low, a high tx_en drives dp_clk_en to 1 in the same cycle, and the state is RUN after the next edge.
- R6: If every power-down cause clears during FLUSH (for example tx_en rises in auto mode), the flush is aborted. The state returns to RUN at the next edge and dp_clk_en never drops.
- R7: out_clk_en is 1 in every state except SLEEP.
- R8: A set sleep_req takes priority over pd_pin, and pd_pin takes priority over auto mode. From RUN, sleep_req runs a flush that ends in SLEEP. From GATED or WAIT_LOCK, sleep_req reaches SLEEP at the next edge. In SLEEP, ana_shutdown is 1 and dp_clk_en, ready and out_clk_en are 0.
- R9: When sleep_req clears in SLEEP, the state becomes WAIT_LOCK, with ready 0 and dp_clk_en 0. The block leaves WAIT_LOCK only on an edge where pll_locked is 1. It goes to GATED if a power-down cause is still present, otherwise to RUN.
- R10: While pd_pin is high, a high tx_en neither re-enables dp_clk_en in GATED nor aborts a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_pin | input | 1 | Hardware power-down request, active high |
| tx_en | input | 1 | Transmit burst enable |
| auto_pd_en | input | 1 | Control bit: automatic power-down between bursts |
| sleep_req | input | 1 | Control bit: full sleep |
| pll_locked | input | 1 | PLL lock indicator |
| dp_clk_en | output | 1 | Datapath clock enable |
| ana_shutdown | output | 1 | Analog section shutdown request |
| ready | output | 1 | Block ready to transmit |
| out_clk_en | output | 1 | Data output clock enable |
| state_o | output | 3 | Current sequencer state |

## Verification
The hardest situations to reach are the ones where requests overlap. Examples are pd_pin falling on the very cycle tx_en rises, a flush being aborted partway through, and sleep_req arriving or clearing while a flush or lock wait is in progress. Directed sequences force each of these overlaps exactly. Long random runs then toggle the five inputs with different per-input probabilities, so that flushes often overlap with late transmit-enable edges and lock delays. Every cycle of both phases is compared against a bench-side reference of the state and all four flag outputs.

// File: rtl/bpd_pkg.sv
// Package: shared state encoding for the burst-aware power-down sequencer.
// Assumes a 3-bit state field; the values are visible on state_o.
package bpd_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        BPD_RUN       = 3'd0,
        BPD_FLUSH     = 3'd1,
        BPD_GATED     = 3'd2,
        BPD_SLEEP     = 3'd3,
        BPD_WAIT_LOCK = 3'd4
    } bpd_state_e;
endpackage

// File: rtl/bpd_flush_timer.sv
// Module: flush timer. Counts the cycles spent in the flush state and
// raises last_cycle on the final flush cycle.
// Assumes FLUSH_CYCLES >= 1 and that in_flush is a registered state decode.
module bpd_flush_timer #(
    parameter int FLUSH_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_flush,
    output logic last_cycle
);
    localparam int CNT_W = $clog2(FLUSH_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(FLUSH_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count up while flushing, restart from zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (in_flush)
            cnt_q <= cnt_q + 1'b1;
        else
            cnt_q <= '0;
    end

    // Final flush cycle reached.
    always_comb last_cycle = in_flush && (cnt_q == LAST_VAL);
endmodule

// File: rtl/bpd_fsm.sv
// Module: sequencer state machine. It resolves the three power-down causes
// by priority (sleep, then pin, then automatic mode), and it holds the
// datapath clock enable across the flush.
// Assumes all inputs are synchronous to clk.
module bpd_fsm
    import bpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_pin,
    input  logic       tx_en,
    input  logic       auto_pd_en,
    input  logic       sleep_req,
    input  logic       pll_locked,
    input  logic       flush_last,
    output bpd_state_e state_q,
    output logic       want_down
);
    bpd_state_e state_d;

    // Any power-down cause active this cycle.
    always_comb want_down = sleep_req || pd_pin || (auto_pd_en && !tx_en);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BPD_RUN: begin
                if (want_down)
                    state_d = BPD_FLUSH;
            end
            BPD_FLUSH: begin
                if (!want_down)
                    state_d = BPD_RUN;
                else if (flush_last)
                    state_d = sleep_req ? BPD_SLEEP : BPD_GATED;
            end
            BPD_GATED: begin
                if (sleep_req)
                    state_d = BPD_SLEEP;
                else if (!want_down)
                    state_d = BPD_RUN;
            end
            BPD_SLEEP: begin
                if (!sleep_req)
                    state_d = BPD_WAIT_LOCK;
            end
            BPD_WAIT_LOCK: begin
                if (sleep_req)
                    state_d = BPD_SLEEP;
                else if (pll_locked)
                    state_d = want_down ? BPD_GATED : BPD_RUN;
            end
            default: state_d = BPD_RUN;
        endcase
    end

    // State register with synchronous reset into RUN.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= BPD_RUN;
        else
            state_q <= state_d;
    end
endmodule

// File: rtl/bpd_out_map.sv
// Module: output decode. It maps the state onto the clock enables and flags.
// In GATED, a cleared power-down cause restores the datapath enable in the
// same cycle, so a new burst loses no clock.
// Assumes want_down comes from the same cycle's inputs.
module bpd_out_map
    import bpd_pkg::*;
(
    input  bpd_state_e               state_q,
    input  logic                     want_down,
    output logic                     dp_clk_en,
    output logic                     ana_shutdown,
    output logic                     ready,
    output logic                     out_clk_en,
    output logic [STATE_W-1:0]       state_o
);
    // Datapath clock runs in RUN and FLUSH, and is bypassed on in GATED when no cause remains.
    always_comb dp_clk_en = (state_q == BPD_RUN) || (state_q == BPD_FLUSH) ||
                            ((state_q == BPD_GATED) && !want_down);

    // Analog shutdown only in full sleep.
    always_comb ana_shutdown = (state_q == BPD_SLEEP);

    // Ready except while asleep or waiting for lock.
    always_comb ready = (state_q != BPD_SLEEP) && (state_q != BPD_WAIT_LOCK);

    // Output data clock stays alive outside full sleep.
    always_comb out_clk_en = (state_q != BPD_SLEEP);

    // Raw state for observation.
    always_comb state_o = state_q;
endmodule

// File: rtl/burst_pd_seq.sv
// Module: top of the burst-aware power-down sequencer. It ties together the
// state machine, the flush timer and the output decode.
// Assumes synchronous inputs and a synchronous active-low reset.
module burst_pd_seq
    import bpd_pkg::*;
#(
    parameter int FLUSH_CYCLES = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pd_pin,
    input  logic               tx_en,
    input  logic               auto_pd_en,
    input  logic               sleep_req,
    input  logic               pll_locked,
    output logic               dp_clk_en,
    output logic               ana_shutdown,
    output logic               ready,
    output logic               out_clk_en,
    output logic [STATE_W-1:0] state_o
);
    bpd_state_e state_q;
    logic       want_down;
    logic       flush_last;
    logic       in_flush;

    // Flush decode for the timer.
    always_comb in_flush = (state_q == BPD_FLUSH);

    bpd_flush_timer #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_flush   (in_flush),
        .last_cycle (flush_last)
    );

    bpd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_pin     (pd_pin),
        .tx_en      (tx_en),
        .auto_pd_en (auto_pd_en),
        .sleep_req  (sleep_req),
        .pll_locked (pll_locked),
        .flush_last (flush_last),
        .state_q    (state_q),
        .want_down  (want_down)
    );

    bpd_out_map u_out (
        .state_q      (state_q),
        .want_down    (want_down),
        .dp_clk_en    (dp_clk_en),
        .ana_shutdown (ana_shutdown),
        .ready        (ready),
        .out_clk_en   (out_clk_en),
        .state_o      (state_o)
    );
endmodule

// File: rtl/burst_pd_seq_chk.sv
// Module: property checker for burst_pd_seq. It is bound to the top and
// watches only the ports.
// Assumes the state encoding from bpd_pkg.
module burst_pd_seq_chk
    import bpd_pkg::*;
#(
    parameter int FLUSH_CYCLES = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pd_pin,
    input logic               tx_en,
    input logic               auto_pd_en,
    input logic               sleep_req,
    input logic               pll_locked,
    input logic               dp_clk_en,
    input logic               ana_shutdown,
    input logic               ready,
    input logic               out_clk_en,
    input logic [STATE_W-1:0] state_o
);
    int   flush_run;
    logic past_ok;

    // Length of the current flush run, counted independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_run <= 0;
            past_ok   <= 1'b0;
        end else begin
            past_ok   <= 1'b1;
            flush_run <= (state_o == BPD_FLUSH) ? flush_run + 1 : 0;
        end
    end

    AST_FLUSH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == BPD_FLUSH) |-> (flush_run < FLUSH_CYCLES)); // R2

    AST_GATED_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && state_o == BPD_GATED && $past(state_o) == BPD_RUN) |-> 1'b0); // R2

    AST_REARM_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == BPD_GATED && tx_en && !pd_pin && !sleep_req) |-> dp_clk_en); // R5

    AST_PIN_HOLDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == BPD_GATED && pd_pin) |-> !dp_clk_en); // R10

    AST_OUT_CLK_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != BPD_SLEEP) |-> out_clk_en); // R7

    AST_SLEEP_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        ana_shutdown |-> (!dp_clk_en && !ready && !out_clk_en)); // R8

    AST_SLEEP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == BPD_GATED && sleep_req) |=> (state_o == BPD_SLEEP)); // R8

    AST_LOCK_GATES_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == BPD_WAIT_LOCK && !pll_locked && !sleep_req) |=> !ready); // R9
endmodule

bind burst_pd_seq burst_pd_seq_chk #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_chk (.*);

// File: tb/burst_pd_seq_tb.sv
// Bench: directed corner cases plus seeded random stimulus, compared every
// cycle against a reference model built from the requirements.
module burst_pd_seq_tb;
    localparam int N = 12;
    localparam logic [2:0] S_RUN = 3'd0, S_FLUSH = 3'd1, S_GATED = 3'd2,
                           S_SLEEP = 3'd3, S_WAIT = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_pin = 1'b0, tx_en = 1'b1, auto_pd_en = 1'b0, sleep_req = 1'b0, pll_locked = 1'b0;
    logic dp_clk_en, ana_shutdown, ready, out_clk_en;
    logic [2:0] state_o;

    int tests = 0, fails = 0, cycles = 0;
    logic [2:0] m_s = S_RUN;
    int m_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    burst_pd_seq #(.FLUSH_CYCLES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .tx_en(tx_en),
        .auto_pd_en(auto_pd_en), .sleep_req(sleep_req), .pll_locked(pll_locked),
        .dp_clk_en(dp_clk_en), .ana_shutdown(ana_shutdown), .ready(ready),
        .out_clk_en(out_clk_en), .state_o(state_o)
    );

    function automatic logic m_down(input logic pd, tx, au, sl);
        return sl | pd | (au & ~tx);
    endfunction

    function automatic logic [2:0] m_next(input logic [2:0] s, input int cnt,
                                          input logic pd, tx, au, sl, lk);
        logic wd;
        wd = m_down(pd, tx, au, sl);
        case (s)
            S_RUN:   return wd ? S_FLUSH : S_RUN;
            S_FLUSH: return !wd ? S_RUN : (cnt == N - 1) ? (sl ? S_SLEEP : S_GATED) : S_FLUSH;
            S_GATED: return sl ? S_SLEEP : (!wd ? S_RUN : S_GATED);
            S_SLEEP: return sl ? S_SLEEP : S_WAIT;
            default: return sl ? S_SLEEP : (lk ? (wd ? S_GATED : S_RUN) : S_WAIT);
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare all outputs with the model for the current cycle.
    task automatic check_outputs();
        logic wd;
        wd = m_down(pd_pin, tx_en, auto_pd_en, sleep_req);
        chk("R2", "state_o", state_o, m_s);
        chk("R5", "dp_clk_en", dp_clk_en,
            (m_s == S_RUN) || (m_s == S_FLUSH) || (m_s == S_GATED && !wd));
        chk("R9", "ready", ready, (m_s != S_SLEEP) && (m_s != S_WAIT));
        chk("R8", "ana_shutdown", ana_shutdown, m_s == S_SLEEP);
        chk("R7", "out_clk_en", out_clk_en, m_s != S_SLEEP);
    endtask

    // Drive one cycle of inputs, check, then advance the model at the edge.
    task automatic step(input logic pd, tx, au, sl, lk);
        logic [2:0] ns;
        @(negedge clk);
        pd_pin = pd; tx_en = tx; auto_pd_en = au; sleep_req = sl; pll_locked = lk;
        #1;
        check_outputs();
        @(posedge clk);
        ns = m_next(m_s, m_cnt, pd, tx, au, sl, lk);
        m_cnt = (m_s == S_FLUSH) ? m_cnt + 1 : 0;
        m_s = ns;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_s = S_RUN;
        m_cnt = 0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_up();
        end
    end

    initial begin
        int highs;
        logic p, t, a, s;
        do_reset();
        #1;
        // R1: reset state
        chk("R1", "reset state_o", state_o, S_RUN);
        chk("R1", "reset dp_clk_en", dp_clk_en, 1);
        chk("R1", "reset ready", ready, 1);
        chk("R1", "reset ana_shutdown", ana_shutdown, 0);
        chk("R1", "reset out_clk_en", out_clk_en, 1);

        // R2: exact flush length from pin request
        highs = 0;
        for (int i = 0; i < N + 4; i++) begin
            step(1, 1, 0, 0, 1);
            if (dp_clk_en) highs++;
        end
        chk("R2", "cycles with dp_clk_en high", highs, N + 1);
        chk("R2", "gated state", state_o, S_GATED);

        // R10: tx_en high with pin high keeps gate closed
        step(1, 1, 1, 0, 1);
        chk("R10", "dp_clk_en with pin high", dp_clk_en, 0);

        // R3: pin falls in the same cycle tx_en rises
        step(1, 0, 1, 0, 1);
        step(0, 1, 1, 0, 1);
        chk("R3", "same-cycle restart dp_clk_en", dp_clk_en, 1);
        step(0, 1, 1, 0, 1);
        chk("R3", "running after restart", state_o, S_RUN);

        // R4: auto disabled, tx low ignored
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1);
        chk("R4", "auto off stays RUN", state_o, S_RUN);

        // R6: auto flush aborted by tx_en
        step(0, 0, 1, 0, 1);
        step(0, 0, 1, 0, 1);
        step(0, 0, 1, 0, 1);
        chk("R6", "flushing", state_o, S_FLUSH);
        step(0, 1, 1, 0, 1);
        step(0, 1, 1, 0, 1);
        chk("R6", "abort to RUN", state_o, S_RUN);

        // R4/R5: auto gate then immediate re-arm
        for (int i = 0; i < N + 3; i++) step(0, 0, 1, 0, 1);
        chk("R4", "auto gated", state_o, S_GATED);
        step(0, 1, 1, 0, 1);
        chk("R5", "re-arm same cycle", dp_clk_en, 1);

        // R8/R9: sleep with pin also high, then wait for lock
        for (int i = 0; i < N + 3; i++) step(1, 1, 0, 1, 0);
        chk("R8", "sleep over pin", state_o, S_SLEEP);
        for (int i = 0; i < 6; i++) step(0, 1, 0, 0, 0);
        chk("R9", "waiting for lock ready", ready, 0);
        step(0, 1, 0, 0, 1);
        step(0, 1, 0, 0, 1);
        chk("R9", "run after lock", state_o, S_RUN);

        // Random phase with sticky, biased toggles.
        void'($urandom(32'h5eed_0042));
        p = 0; t = 1; a = 0; s = 0;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(15) == 0) p = ~p;
            if ($urandom_range(9) == 0) t = ~t;
            if ($urandom_range(39) == 0) a = ~a;
            if ($urandom_range(79) == 0) s = ~s;
            step(p, t, a, s, $urandom_range(2) == 0);
        end
        finish_up();
    end
endmodule